// File: doc/BRIEF.md
# Dual-Mode Four-Bit Set/Reset Latch Bank

This block is a bank of four level-sensitive storage bits that share one active-low enable and one active-low master reset. Each bit has its own data line and its own active-low set line. A low on the data line clears the bit. A low on the set line sets the bit, but only while the data line is high. So one storage cell serves two purposes. If its set line is tied low, it works as a plain transparent D latch. If both of its lines are driven as strobes, it works as a set/reset latch in which clearing wins.

The block has no clock. While the enable is low, the bits respond to their inputs at once. When the enable rises, every bit keeps the value it had just before and no longer reacts to its data or set lines. The master reset acts independently of the enable and wins over every other input. The value of the bits after power-up is undefined until the first master reset or the first enabled write.

Top module: `quad_sr_latch`

## Requirements
- R1: The four bits are independent: the data and set lines of one bit never change another bit.
- R2: While `en_n` is high and `mr_n` is high, every bit holds the value it had when `en_n` rose, whatever its data and set lines do.
- R3: While `mr_n` is low, every output bit is 0, whatever the values of `en_n`, `d` and `s_n`.
- R4: With `en_n` low and `mr_n` high, a bit whose `d` line is 0 reads 0.
- R5: With `en_n` low and `mr_n` high, a bit whose `s_n` line is 0 and whose `d` line is 1 reads 1.
- R6: With `en_n` low and `mr_n` high, a bit whose `d` and `s_n` lines are both 0 reads 0: clearing wins over setting.
- R7: With `en_n` low and `mr_n` high, a bit whose `d` and `s_n` lines are both 1 keeps its previous value.
- R8: With `en_n` low and `mr_n` high, a bit whose `s_n` line is 0 follows its `d` line as a D latch.
- R9: When `mr_n` is released while `en_n` is high, all bits stay 0 until an enabled write changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mr_n | input | 1 | Master reset, active low; clears every bit and wins over all other inputs |
| en_n | input | 1 | Shared enable, active low; when high, all bits hold |
| d | input | 4 | Per-bit data line; 0 clears the bit while enabled |
| s_n | input | 4 | Per-bit set line, active low; sets the bit while enabled if its data line is 1 |
| q | output | 4 | Stored bit values |

## Verification
Two controls can act on a bit at the same moment: the master reset and an enabled clear or set request. A second case is the enable rising while the data and set lines keep changing. The bench makes reset and enable low together while the data and set lines ask for a set. It requires all zeros, then releases reset with the enable high and requires the zeros to remain. To test hold, the bench first stores a mixed pattern and raises the enable. It then toggles every data and set line in several patterns and checks the stored pattern after each change. A per-bit reference model compares results on every input change, both during a walk through all sixteen control and input combinations and during seeded random sequences.

// File: rtl/qsr_pkg.sv
// Package: shared width and the per-bit request encoding for the latch bank.
// Assumes: all modules of the bank import this package.
package qsr_pkg;

    localparam int unsigned QSR_BITS = 4;

    // Request that a bit's data and set lines make while the bank is enabled.
    typedef enum logic [1:0] {
        REQ_HOLD  = 2'd0,
        REQ_CLEAR = 2'd1,
        REQ_SET   = 2'd2
    } qsr_req_e;

endpackage

// File: rtl/qsr_decode.sv
// Module: qsr_decode
// Turns one bit's data and set lines into a storage request. A low data line
// clears the bit and wins over set. A low set line with a high data line sets
// the bit. With both lines high the bit is left alone.
// Assumes: purely combinational; enable and reset are applied in the cell.
module qsr_decode
    import qsr_pkg::*;
(
    input  logic     d,
    input  logic     s_n,
    output qsr_req_e req
);

    // Priority decode: clear first, then set, otherwise hold.
    always_comb begin
        if (!d) begin
            req = REQ_CLEAR;
        end else if (!s_n) begin
            req = REQ_SET;
        end else begin
            req = REQ_HOLD;
        end
    end

endmodule

// File: rtl/qsr_cell.sv
// Module: qsr_cell
// One level-sensitive storage bit. An active-low master reset clears it at any
// time. While the active-low enable is low, the bit applies the decoded
// request; while the enable is high, it keeps its value.
// Assumes: no clock; the power-up value is undefined until a reset or write.
module qsr_cell
    import qsr_pkg::*;
(
    input  logic     mr_n,
    input  logic     en_n,
    input  logic     d,
    input  logic     s_n,
    output logic     q
);

    qsr_req_e req;
    logic     q_r;

    qsr_decode u_dec (
        .d   (d),
        .s_n (s_n),
        .req (req)
    );

    // Storage: reset overrides, enabled requests update, otherwise hold.
    always_latch begin
        if (!mr_n) begin
            q_r = 1'b0;
        end else if (!en_n) begin
            if (req == REQ_CLEAR) begin
                q_r = 1'b0;
            end else if (req == REQ_SET) begin
                q_r = 1'b1;
            end
        end
    end

    assign q = q_r;

    // Guards: the stored value agrees with the controls that are active now.
    always_comb begin
        if (!mr_n) begin
            p_reset_forces_low_r3: assert (q_r == 1'b0);
        end
        if (mr_n && !en_n && !d) begin
            p_data_low_clears_r6: assert (q_r == 1'b0);
        end
        if (mr_n && !en_n && d && !s_n) begin
            p_set_when_data_high_r5: assert (q_r == 1'b1);
        end
        if (mr_n && !en_n && !s_n) begin
            p_dlatch_follows_r8: assert (q_r == d);
        end
    end

endmodule

// File: rtl/quad_sr_latch.sv
// Module: quad_sr_latch
// A bank of independent set/reset-capable latch bits that share one
// active-low enable and one active-low master reset.
// Assumes: the width comes from the package; each bit is a separate qsr_cell.
module quad_sr_latch
    import qsr_pkg::*;
(
    input  logic                mr_n,
    input  logic                en_n,
    input  logic [QSR_BITS-1:0] d,
    input  logic [QSR_BITS-1:0] s_n,
    output logic [QSR_BITS-1:0] q
);

    // One storage cell per bit, each fed the shared controls.
    for (genvar gi = 0; gi < QSR_BITS; gi++) begin : g_bit
        qsr_cell u_cell (
            .mr_n (mr_n),
            .en_n (en_n),
            .d    (d[gi]),
            .s_n  (s_n[gi]),
            .q    (q[gi])
        );
    end

endmodule

// File: tb/sim_quad_sr_latch.sv
// Bench for quad_sr_latch. It changes one set of inputs per clock, then
// compares the outputs with a per-bit reference model half a period later.
module sim_quad_sr_latch;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          mr_n = 1'b0;
    logic          en_n = 1'b1;
    logic [NB-1:0] d = '1;
    logic [NB-1:0] s_n = '1;
    logic [NB-1:0] q;
    logic [NB-1:0] exp_q = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    quad_sr_latch u0 (
        .mr_n (mr_n),
        .en_n (en_n),
        .d    (d),
        .s_n  (s_n),
        .q    (q)
    );

    // Reference model: the next value of every bit, computed from the rules.
    function automatic logic [NB-1:0] ref_next(logic mr, logic en,
            logic [NB-1:0] dd, logic [NB-1:0] ss, logic [NB-1:0] prev);
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) begin
            if (!mr) r[i] = 1'b0;
            else if (en) r[i] = prev[i];
            else if (!dd[i]) r[i] = 1'b0;
            else if (!ss[i]) r[i] = 1'b1;
            else r[i] = prev[i];
        end
        return r;
    endfunction

    task automatic check(string req);
        n_checks++;
        if (q !== exp_q) begin
            n_errors++;
            $display("FAIL %s: q=%b expected %b (mr_n=%b en_n=%b d=%b s_n=%b)",
                     req, q, exp_q, mr_n, en_n, d, s_n);
        end
    endtask

    // Apply inputs after a rising edge, update the model, check at the falling edge.
    task automatic apply(logic mr, logic en, logic [NB-1:0] dd,
                         logic [NB-1:0] ss, string req);
        @(posedge clk);
        #1;
        mr_n = mr; en_n = en; d = dd; s_n = ss;
        exp_q = ref_next(mr, en, dd, ss, exp_q);
        @(negedge clk);
        check(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        // R3: reset state with mixed inputs and enable low asking for set.
        apply(1'b0, 1'b1, 4'b1111, 4'b1111, "R3 reset state");
        apply(1'b0, 1'b0, 4'b1111, 4'b0000, "R3 reset beats enabled set");
        // R9: release reset with enable high; zeros remain.
        apply(1'b1, 1'b1, 4'b1111, 4'b0000, "R9 release with enable high");
        apply(1'b1, 1'b1, 4'b0101, 4'b0000, "R9 inputs toggle after release");

        // R5 set, R4 clear, R6 dominance, R7 hold, on directed patterns.
        apply(1'b1, 1'b0, 4'b1111, 4'b0000, "R5 set all");
        apply(1'b1, 1'b0, 4'b1111, 4'b1111, "R7 hold all high");
        apply(1'b1, 1'b0, 4'b0000, 4'b0000, "R6 data wins over set");
        apply(1'b1, 1'b0, 4'b1111, 4'b1111, "R7 hold all low");
        apply(1'b1, 1'b0, 4'b1010, 4'b1111, "R4 data low clears");
        apply(1'b1, 1'b0, 4'b1111, 4'b1010, "R5 partial set");
        apply(1'b1, 1'b0, 4'b1110, 4'b1110, "R1 R4 one bit cleared");

        // R8: set low makes a D latch following data.
        apply(1'b1, 1'b0, 4'b1001, 4'b0000, "R8 follow 1001");
        apply(1'b1, 1'b0, 4'b0110, 4'b0000, "R8 follow 0110");
        apply(1'b1, 1'b0, 4'b0011, 4'b0000, "R8 follow 0011");

        // R2: store a mixed pattern, disable, toggle inputs.
        apply(1'b1, 1'b0, 4'b0110, 4'b1001, "R6 R5 mixed store");
        apply(1'b1, 1'b0, 4'b0110, 4'b0000, "R8 mixed store");
        apply(1'b1, 1'b1, 4'b0110, 4'b0000, "R2 enable rises");
        apply(1'b1, 1'b1, 4'b0000, 4'b0000, "R2 data low ignored");
        apply(1'b1, 1'b1, 4'b1111, 4'b0000, "R2 set ignored");
        apply(1'b1, 1'b1, 4'b1001, 4'b0110, "R2 mixed ignored");
        apply(1'b1, 1'b1, 4'b1111, 4'b1111, "R2 idle ignored");

        // Truth-table walk: every {mr_n,en_n,d,s_n} on each bit, others idle.
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < 16; c++) begin
                logic [NB-1:0] dd;
                logic [NB-1:0] ss;
                dd = '1;
                ss = '1;
                dd[b] = c[1];
                ss[b] = c[0];
                apply(c[3], c[2], dd, ss, "R1 R4 R5 R6 R7 truth-table walk");
            end
        end

        // Seeded random sequences; reset asserted occasionally.
        for (int k = 0; k < 600; k++) begin
            logic mr;
            logic en;
            mr = ($urandom_range(15) != 0);
            en = ($urandom_range(2) == 0);
            apply(mr, en, NB'($urandom), NB'($urandom),
                  "R1 R2 R3 R8 random");
        end

        finish_run();
    end

endmodule